// File: doc/BRIEF.md
# Half-Duplex Serial Transceiver

This block is a single-channel asynchronous serial port that moves data in one direction at a time. A single bit-period timer and a single 8-bit shift register serve both directions. While idle it watches the receive line. A falling edge, seen after a two-flop synchronizer, starts the capture of one frame: a start bit, eight data bits sent least significant bit first, and one stop bit. The received byte is then copied into a holding register and a ready flag is raised.

A one-cycle `tx_start` pulse loads `tx_data` into the shared shift register and sends one frame on `txd`. A transmit request always wins. It cuts short a reception or a transmission already in progress and starts over with the new byte. Falling edges on the receive line are ignored while a frame is being sent.

The bit period is BIT_DIV × PRESCALE system clocks. The product must lie between 17 and 170. The external reset is asynchronous, active low, and is released through a two-stage synchronizer inside the block.

Top module: `hdx_uart`

## Requirements
- R1: After reset `txd` is 1, `busy`, `tx_busy` and `rx_ready` are 0, and `rx_data` is 0x00.
- R2: Every transmitted bit, including the start bit, lasts exactly BIT_DIV × PRESCALE clock cycles.
- R3: In idle, a falling edge on the synchronized `rxd` starts a reception. `busy` goes to 1, `tx_busy` stays 0 and `rx_ready` is cleared.
- R4: The first data bit is sampled 1.5 bit periods after the start edge and each later bit one bit period after the one before. Bits arrive least significant bit first, so the first bit received ends up in bit 0 of `rx_data`.
- R5: On the ninth bit tick the stop bit is sampled and dropped, whatever its level. The byte is copied to `rx_data`, `rx_ready` is set, `busy` is cleared, and a new start edge is accepted from then on.
- R6: A transmitted frame is a low start bit, then the eight data bits with bit 0 first, then a high stop bit. After ten bit periods `busy` and `tx_busy` return to 0.
- R7: A `tx_start` during a reception abandons it. `rx_ready` stays 0, `rx_data` is unchanged, and the new frame is sent intact.
- R8: A `tx_start` during a transmission restarts the frame at its start bit with the new byte.
- R9: `tx_busy` is 1 exactly while a frame is being sent, and `busy` is 1 then as well. Starting a transmission leaves `rx_ready` and `rx_data` unchanged.
- R10: `rx_ready` stays set until a one-cycle `rx_read` pulse or the start of a new reception clears it. A completion in the same cycle as a read leaves it set.
- R11: Falling edges on `rxd` while transmitting start no reception. After the frame the block is idle with `rx_ready` and `rx_data` unchanged.
- R12: `txd` is 1 at every cycle in which no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idles high |
| txd | output | 1 | Serial transmit line, idles high |
| tx_data | input | 8 | Byte to send, sampled on `tx_start` |
| tx_start | input | 1 | One-cycle transmit request |
| rx_data | output | 8 | Last byte received |
| rx_read | input | 1 | One-cycle pulse that clears `rx_ready` |
| rx_ready | output | 1 | A received byte is waiting |
| busy | output | 1 | A frame is being received or sent |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The bench sends frames whose stop bit is driven low. A design that checked the stop bit would drop those bytes, and one that missed re-arming edge detection would then miss the next frame. It starts a transmit in the middle of a reception and in the middle of another transmit. A design without a clean abort would let old bits leak onto `txd` or raise `rx_ready` for a broken byte. It drives a whole receive frame while a byte is going out, which catches any design that reacts to edges during a transmit. It measures the start-bit width and samples the data bits at the 1.5-period point, so an off-by-one in the timer reload or the half-period offset shows up as a shifted or wrong byte.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_TX   = 2'd2
  } hdx_state_e;

  typedef enum logic [1:0] {
    SH_HOLD = 2'd0,
    SH_LOAD = 2'd1,
    SH_IN   = 2'd2,
    SH_OUT  = 2'd3
  } hdx_shift_op_e;

endpackage

// File: rtl/hdx_rx_sync.sv
module hdx_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], rxd};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign fall  = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/hdx_bit_timer.sv
module hdx_bit_timer #(
  parameter int BIT_DIV  = 12,
  parameter int PRESCALE = 2,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             halt,
  output logic             tick
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pre_last;

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_en;

      always_comb begin
        pre_d  = pre_q;
        pre_en = 1'b0;
        if (load) begin
          pre_d  = '0;
          pre_en = 1'b1;
        end else if (run_q) begin
          pre_d  = (pre_q == PRE_W'(PRESCALE - 1)) ? '0 : pre_q + PRE_W'(1);
          pre_en = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (pre_en) begin
          pre_q <= pre_d;
        end
      end

      assign pre_last = (pre_q == PRE_W'(PRESCALE - 1));
    end else begin : g_nopre
      assign pre_last = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load) begin
      cnt_d = load_val - CNT_W'(1);
      run_d = 1'b1;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (run_q && pre_last) begin
      cnt_d = (cnt_q == '0) ? CNT_W'(BIT_DIV - 1) : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign tick = run_q & pre_last & (cnt_q == '0);

endmodule

// File: rtl/hdx_shift_reg.sv
module hdx_shift_reg
  import hdx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hdx_shift_op_e    op,
  input  logic [WIDTH-1:0] load_val,
  input  logic             in_bit,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r, q_d;
  logic             en;

  always_comb begin
    unique case (op)
      SH_LOAD: q_d = load_val;
      SH_IN:   q_d = {in_bit, q_r[WIDTH-1:1]};
      SH_OUT:  q_d = {1'b0, q_r[WIDTH-1:1]};
      default: q_d = q_r;
    endcase
  end

  assign en = (op != SH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (en) begin
      q_r <= q_d;
    end
  end

  assign q = q_r;

endmodule

// File: rtl/hdx_uart.sv
module hdx_uart
  import hdx_pkg::*;
#(
  parameter int BIT_DIV     = 12,
  parameter int PRESCALE    = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  output logic              txd,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_read,
  output logic              rx_ready,
  output logic              busy,
  output logic              tx_busy
);

  localparam int HALF_LOAD = BIT_DIV + BIT_DIV / 2;
  localparam int CNT_W     = $clog2(HALF_LOAD + 1);
  localparam int BCNT_W    = $clog2(DATA_W + 2);

  // Reset release synchronizer
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  // Sub-blocks
  logic              rx_level, rx_fall, tick;
  logic              t_load, t_halt;
  logic [CNT_W-1:0]  t_val;
  hdx_shift_op_e     sh_op;
  logic [DATA_W-1:0] sh_q;

  hdx_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rxd   (rxd),
    .level (rx_level),
    .fall  (rx_fall)
  );

  hdx_bit_timer #(.BIT_DIV(BIT_DIV), .PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (t_load),
    .load_val (t_val),
    .halt     (t_halt),
    .tick     (tick)
  );

  hdx_shift_reg #(.WIDTH(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op       (sh_op),
    .load_val (tx_data),
    .in_bit   (rx_level),
    .q        (sh_q)
  );

  // Control state
  hdx_state_e        state_q, state_d;
  logic [BCNT_W-1:0] bit_q, bit_d;
  logic              txd_q, txd_d;
  logic              rdr_q, rdr_d;
  logic [DATA_W-1:0] rxbuf_q;
  logic              rxbuf_en;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    txd_d    = txd_q;
    rdr_d    = rdr_q;
    rxbuf_en = 1'b0;
    t_load   = 1'b0;
    t_halt   = 1'b0;
    t_val    = CNT_W'(BIT_DIV);
    sh_op    = SH_HOLD;

    if (rx_read) begin
      rdr_d = 1'b0;
    end

    if (tx_start) begin
      // A transmit request overrides whatever is in progress
      state_d = ST_TX;
      t_load  = 1'b1;
      t_val   = CNT_W'(BIT_DIV);
      bit_d   = '0;
      sh_op   = SH_LOAD;
      txd_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rx_fall) begin
            state_d = ST_RX;
            t_load  = 1'b1;
            t_val   = CNT_W'(HALF_LOAD);
            bit_d   = '0;
            rdr_d   = 1'b0;
          end
        end
        ST_RX: begin
          if (tick) begin
            if (bit_q == BCNT_W'(DATA_W)) begin
              // stop bit slot: data kept, stop level dropped
              rxbuf_en = 1'b1;
              rdr_d    = 1'b1;
              state_d  = ST_IDLE;
              t_halt   = 1'b1;
            end else begin
              sh_op = SH_IN;
              bit_d = bit_q + BCNT_W'(1);
            end
          end
        end
        ST_TX: begin
          if (tick) begin
            if (bit_q < BCNT_W'(DATA_W)) begin
              txd_d = sh_q[0];
              sh_op = SH_OUT;
              bit_d = bit_q + BCNT_W'(1);
            end else if (bit_q == BCNT_W'(DATA_W)) begin
              txd_d = 1'b1;
              bit_d = bit_q + BCNT_W'(1);
            end else begin
              state_d = ST_IDLE;
              t_halt  = 1'b1;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      txd_q   <= 1'b1;
      rdr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      txd_q   <= txd_d;
      rdr_q   <= rdr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rxbuf_q <= '0;
    end else if (rxbuf_en) begin
      rxbuf_q <= sh_q;
    end
  end

  assign txd      = txd_q;
  assign rx_data  = rxbuf_q;
  assign rx_ready = rdr_q;
  assign busy     = (state_q != ST_IDLE);
  assign tx_busy  = (state_q == ST_TX);

endmodule

// File: rtl/hdx_uart_chk.sv
module hdx_uart_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txd,
  input logic              tx_start,
  input logic              rx_read,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              busy,
  input logic              tx_busy
);

  assert_txd_idle_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_start_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (tx_busy && !txd));

  assert_ready_from_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> ($past(busy) && !$past(tx_busy) && !busy));

  assert_ready_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> ($past(rx_read) || (busy && !tx_busy)));

  assert_rxdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(tx_busy) && !busy) || $stable(rx_data));

  assert_no_rx_in_tx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_start) |=> (tx_busy || !busy));

endmodule

bind hdx_uart hdx_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .txd      (txd),
  .tx_start (tx_start),
  .rx_read  (rx_read),
  .rx_data  (rx_data),
  .rx_ready (rx_ready),
  .busy     (busy),
  .tx_busy  (tx_busy)
);

// File: tb/sim_hdx_uart.sv
module sim_hdx_uart;

  localparam int CLK_PERIOD = 10;
  localparam int N_DIV      = 12;
  localparam int C_PRE      = 2;
  localparam int BIT        = N_DIV * C_PRE;
  localparam int FIRST      = (N_DIV + N_DIV / 2) * C_PRE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       txd;
  logic [7:0] tx_data = 8'h00;
  logic       tx_start = 1'b0;
  logic [7:0] rx_data;
  logic       rx_read = 1'b0;
  logic       rx_ready;
  logic       busy;
  logic       tx_busy;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  cmp_en = 1'b0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdx_uart #(.BIT_DIV(N_DIV), .PRESCALE(C_PRE), .DATA_W(8), .SYNC_STAGES(2)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd      (rxd),
    .txd      (txd),
    .tx_data  (tx_data),
    .tx_start (tx_start),
    .rx_data  (rx_data),
    .rx_read  (rx_read),
    .rx_ready (rx_ready),
    .busy     (busy),
    .tx_busy  (tx_busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 receiving, 2 sending
  int m_p1 = 0, m_p2 = 0;
  int m_s1 = 1, m_s2 = 1, m_d = 1;
  int m_mode = 0, m_cnt = 0, m_bit = 0, m_sh = 0;
  int m_txd = 1, m_rdr = 0, m_rxdata = 0;

  task automatic model_clear();
    m_s1 = 1; m_s2 = 1; m_d = 1;
    m_mode = 0; m_cnt = 0; m_bit = 0; m_sh = 0;
    m_txd = 1; m_rdr = 0; m_rxdata = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0;
      model_clear();
    end else begin
      int active;
      int fall;
      int samp;
      active = m_p2;
      m_p2 = m_p1;
      m_p1 = 1;
      if (active == 0) begin
        model_clear();
      end else begin
        fall = (m_d == 1 && m_s2 == 0) ? 1 : 0;
        samp = m_s2;
        m_d = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
        if (rx_read) m_rdr = 0;
        if (tx_start) begin
          m_mode = 2; m_cnt = BIT; m_bit = 0; m_sh = int'(tx_data); m_txd = 0;
        end else if (m_mode == 0) begin
          if (fall == 1) begin
            m_mode = 1; m_cnt = FIRST; m_bit = 0; m_rdr = 0;
          end
        end else begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_cnt = BIT;
            if (m_mode == 1) begin
              if (m_bit == 8) begin
                m_rxdata = m_sh; m_rdr = 1; m_mode = 0;
              end else begin
                m_sh = (samp << 7) | (m_sh >> 1);
                m_bit++;
              end
            end else begin
              if (m_bit < 8) begin
                m_txd = m_sh & 1; m_sh = m_sh >> 1; m_bit++;
              end else if (m_bit == 8) begin
                m_txd = 1; m_bit++;
              end else begin
                m_mode = 0;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R6 R12 txd per clock", txd, m_txd);
      chk("R9 busy per clock", busy, (m_mode != 0));
      chk("R9 tx_busy per clock", tx_busy, (m_mode == 2));
      chk("R10 rx_ready per clock", rx_ready, m_rdr);
      chk("R4 rx_data per clock", rx_data, m_rxdata);
    end
  end

  task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop_lvl;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic pulse_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  task automatic tx_send_check(input logic [7:0] b, input string tag);
    logic [7:0] got;
    pulse_tx(b);
    repeat (BIT / 2 - 1) @(negedge clk);
    chk({tag, " start bit low"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = txd;
    end
    chk({tag, " data byte on line"}, got, b);
    repeat (BIT) @(negedge clk);
    chk({tag, " stop bit high"}, txd, 1);
    repeat (BIT / 2 + 2) @(negedge clk);
    chk({tag, " idle after frame"}, busy, 0);
  endtask

  task automatic read_pulse();
    @(negedge clk);
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 reset state
    chk("R1 txd", txd, 1);
    chk("R1 busy", busy, 0);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 rx_data", rx_data, 8'h00);

    // R3 R4 R5 basic reception
    fork
      send_rx(8'hA5, 1'b1);
      begin
        repeat (6) @(negedge clk);
        chk("R3 busy at start", busy, 1);
        chk("R3 tx_busy at start", tx_busy, 0);
      end
    join
    repeat (5) @(negedge clk);
    chk("R4 rx byte A5", rx_data, 8'hA5);
    chk("R5 ready set", rx_ready, 1);
    chk("R5 busy cleared", busy, 0);

    // R10 ready holds until read
    repeat (50) @(negedge clk);
    chk("R10 ready held", rx_ready, 1);
    read_pulse();
    chk("R10 ready cleared by read", rx_ready, 0);

    // R4 more patterns
    send_rx(8'h3C, 1'b1); repeat (5) @(negedge clk);
    chk("R4 rx byte 3C", rx_data, 8'h3C); read_pulse();
    send_rx(8'h00, 1'b1); repeat (5) @(negedge clk);
    chk("R4 rx byte 00", rx_data, 8'h00); read_pulse();
    send_rx(8'hFF, 1'b1); repeat (5) @(negedge clk);
    chk("R4 rx byte FF", rx_data, 8'hFF);

    // R3 R10 new reception clears an unread flag
    fork
      send_rx(8'h81, 1'b1);
      begin
        repeat (6) @(negedge clk);
        chk("R3 R10 ready cleared at start", rx_ready, 0);
      end
    join
    repeat (5) @(negedge clk);
    chk("R4 rx byte 81", rx_data, 8'h81);

    // R5 low stop bit is dropped, then re-armed
    send_rx(8'h42, 1'b0); repeat (5) @(negedge clk);
    chk("R5 byte with low stop", rx_data, 8'h42);
    chk("R5 ready with low stop", rx_ready, 1);
    repeat (BIT) @(negedge clk);
    send_rx(8'h7E, 1'b1); repeat (5) @(negedge clk);
    chk("R5 re-armed next byte", rx_data, 8'h7E);
    chk("R5 re-armed ready", rx_ready, 1);

    // R6 R9 transmit
    tx_send_check(8'h5A, "R6 tx 5A");
    tx_send_check(8'hC3, "R6 tx C3");
    chk("R9 ready kept across tx", rx_ready, 1);
    chk("R9 rx_data kept across tx", rx_data, 8'h7E);

    // R2 start bit width
    begin
      int low_cnt;
      low_cnt = 0;
      pulse_tx(8'hA5);
      while (txd == 1'b0 && low_cnt < 4 * BIT) begin
        low_cnt++;
        @(negedge clk);
      end
      chk("R2 start bit clocks", low_cnt, BIT);
      repeat (10 * BIT) @(negedge clk);
      chk("R2 frame finished", busy, 0);
    end

    // R11 receive edges ignored while sending
    fork
      tx_send_check(8'h33, "R11 tx during rx activity");
      begin
        repeat (BIT) @(negedge clk);
        send_rx(8'hD5, 1'b1);
      end
    join
    repeat (BIT) @(negedge clk);
    chk("R11 busy after", busy, 0);
    chk("R11 ready unchanged", rx_ready, 1);
    chk("R11 rx_data unchanged", rx_data, 8'h7E);

    // R7 transmit aborts a reception
    fork
      send_rx(8'h96, 1'b1);
      begin
        repeat (4 * BIT) @(negedge clk);
        tx_send_check(8'h3C, "R7 abort rx");
      end
    join
    repeat (BIT) @(negedge clk);
    chk("R7 ready stays clear", rx_ready, 0);
    chk("R7 rx_data unchanged", rx_data, 8'h7E);
    chk("R7 idle", busy, 0);

    // R8 transmit restart
    pulse_tx(8'h11);
    repeat (3 * BIT) @(negedge clk);
    tx_send_check(8'hE7, "R8 restart");

    // R12 line idle high
    repeat (20) @(negedge clk);
    chk("R12 txd idle", txd, 1);

    finish_run();
  end

endmodule